// File: doc/BRIEF.md
# Multiphase Phase-Accumulator Clock Generator with Double-Data-Rate Output

This block synthesizes an adjustable clock waveform from a phase accumulator. The waveform's time resolution is finer than one fabric clock period. In every fabric clock cycle it evaluates several consecutive accumulator phases side by side. Each phase is the running base plus a whole multiple of the tuning word, and the top bit of each phase becomes one bit of a parallel vector. A second clock runs at twice the fabric rate with rising edges aligned to the fabric clock. In that domain the vector is emitted two bits per fast cycle, one for the rising half and one for the falling half. With four phases the waveform behaves like a single accumulator clocked at twice the fastest real clock. A 250 MHz fabric clock therefore gives an effective 1 GHz sample grid.

The output frequency is tuning_word / 2^ACC_W times the effective sample rate. The resolution of the frequency setting is set by the accumulator width. The worst-case edge jitter is one effective sample period. A constant logic delay only shifts the phase of the output. It adds no jitter.

The serial stream is modelled as a pair of bits per fast cycle: the bit for the rising half and the bit for the falling half. A behavioural output stage downstream turns the pair into a pin waveform. The parallel vector is also brought out.

Top module: `mphase_dds_ddr`

## Requirements
- R1: While reset is high, and after reset until the first vector has been captured into the fast domain, msb_vec_o, ser_rise_o and ser_fall_o are all 0. Reset also clears the base phase and the held increment.
- R2: After each fabric rising edge, bit k of msb_vec_o (k = 0..3, bit 0 being the earliest phase) equals bit ACC_W-1 of (B + k*I) mod 2^ACC_W. B and I are the base phase and the held increment in place just before that edge.
- R3: The base phase advances by 4*I modulo 2^ACC_W on every fabric edge out of reset, so consecutive vectors form one unbroken phase sequence, including across wrap-around.
- R4: When tune_load_i is high at a fabric edge, tune_word_i becomes the held increment. The vector registered at the next fabric edge uses it for all four phases, and the vector registered at the load edge uses the old increment for all four phases.
- R5: A change of tune_word_i with tune_load_i low has no effect. A load asserted while reset is high is also ignored, because reset wins.
- R6: Serial order within one fabric period: bit 0 on ser_rise_o and bit 1 on ser_fall_o during the first fast cycle, then bit 2 on ser_rise_o and bit 3 on ser_fall_o during the second.
- R7: A vector registered at fabric edge t appears as the bit 0/1 pair from the fast rising edge one fast period after t. The bit 2/3 pair follows from the next fast rising edge and is held until the following capture.
- R8: Every registered vector is emitted exactly once: one capture per fabric cycle, with no gap and no repeat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fab_i | input | 1 | Fabric clock |
| clk_fast_i | input | 1 | Serializer clock, twice the fabric rate, rising edges aligned |
| rst_i | input | 1 | Synchronous active-high reset, seen by both domains |
| tune_word_i | input | ACC_W | Phase increment per effective sample |
| tune_load_i | input | 1 | Loads tune_word_i at the fabric edge |
| ser_rise_o | output | 1 | Serial bit for the rising half of the fast cycle |
| ser_fall_o | output | 1 | Serial bit for the falling half of the fast cycle |
| msb_vec_o | output | NUM_PHASES | Registered top bits of the parallel phases |

## Verification
Two functions can land in the same fabric cycle. The first is a tuning load. The second is the registering of a vector whose four phases must all still use the previous increment, while the fast domain captures the previous vector at the same moment. The bench provokes this in three ways: back-to-back loads with a different word on every cycle, loads while the accumulator is wrapping, and a near-full negative step. A reference model of base and increment in the bench predicts each vector and its four serial bits. A vector that mixes old and new increments, or a pair emitted a fast cycle early or late, shows up as a mismatch on msb_vec_o or on the rise/fall pair.

// File: rtl/dds_pkg.sv
package dds_pkg;

  localparam int unsigned DEF_ACC_W      = 32;
  localparam int unsigned DEF_NUM_PHASES = 4;

  typedef struct packed {
    logic rise;
    logic fall;
  } ddr_pair_t;

endpackage

// File: rtl/dds_lane_bank.sv
module dds_lane_bank #(
  parameter int unsigned ACC_W      = 32,
  parameter int unsigned NUM_PHASES = 4
) (
  input  logic [ACC_W-1:0]      base_i,
  input  logic [ACC_W-1:0]      inc_i,
  output logic [NUM_PHASES-1:0] msb_o
);

  localparam int unsigned TOP = ACC_W - 1;

  for (genvar k = 0; k < NUM_PHASES; k++) begin : g_lane
    logic [ACC_W-1:0] lane_ph;
    assign lane_ph  = base_i + (inc_i * ACC_W'(k));
    assign msb_o[k] = lane_ph[TOP];
  end

endmodule

// File: rtl/dds_phase_core.sv
module dds_phase_core #(
  parameter int unsigned ACC_W      = 32,
  parameter int unsigned NUM_PHASES = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic [ACC_W-1:0]      tune_word_i,
  input  logic                  tune_load_i,
  output logic [NUM_PHASES-1:0] msb_vec_o,
  output logic                  vec_tgl_o
);

  localparam logic [ACC_W-1:0] STEP_MUL = ACC_W'(NUM_PHASES);

  logic [ACC_W-1:0]      base_q;
  logic [ACC_W-1:0]      inc_q;
  logic [NUM_PHASES-1:0] lane_msb;
  logic [NUM_PHASES-1:0] msb_q;
  logic                  tgl_q;

  dds_lane_bank #(
    .ACC_W     (ACC_W),
    .NUM_PHASES(NUM_PHASES)
  ) lanes_i (
    .base_i(base_q),
    .inc_i (inc_q),
    .msb_o (lane_msb)
  );

  // increment changes only on the fabric edge, so all lanes of a cycle agree
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      inc_q <= '0;
    end else if (tune_load_i) begin
      inc_q <= tune_word_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      base_q <= '0;
      msb_q  <= '0;
      tgl_q  <= 1'b0;
    end else begin
      base_q <= base_q + (inc_q * STEP_MUL);
      msb_q  <= lane_msb;
      tgl_q  <= ~tgl_q;
    end
  end

  assign msb_vec_o = msb_q;
  assign vec_tgl_o = tgl_q;

  AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(tune_load_i)) |-> (inc_q == $past(tune_word_i))); // R4

  AST_HOLD_NOLOAD: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && !$past(tune_load_i)) |-> $stable(inc_q)); // R5

  AST_LANE0_MSB: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) |-> (msb_q[0] == $past(base_q[ACC_W-1]))); // R2

endmodule

// File: rtl/dds_ddr_serializer.sv
module dds_ddr_serializer
  import dds_pkg::*;
#(
  parameter int unsigned NUM_PHASES = 4
) (
  input  logic                  clk_fast_i,
  input  logic                  rst_i,
  input  logic [NUM_PHASES-1:0] vec_i,
  input  logic                  vec_tgl_i,
  output ddr_pair_t             pair_o
);

  logic                  tgl_seen_q;
  logic                  cap;
  logic                  primed_q;
  logic [NUM_PHASES-1:0] sh_q;
  ddr_pair_t             pair_q;

  // the token flips on every fabric edge; it is seen one fast period later,
  // when the vector is settled
  assign cap = (vec_tgl_i != tgl_seen_q);

  always_ff @(posedge clk_fast_i) begin
    if (rst_i) begin
      tgl_seen_q <= 1'b0;
      primed_q   <= 1'b0;
      sh_q       <= '0;
      pair_q     <= '0;
    end else begin
      tgl_seen_q <= vec_tgl_i;
      if (cap) begin
        primed_q    <= 1'b1;
        pair_q.rise <= vec_i[0];
        pair_q.fall <= vec_i[1];
        sh_q        <= vec_i >> 2;
      end else begin
        pair_q.rise <= sh_q[0];
        pair_q.fall <= sh_q[1];
        sh_q        <= sh_q >> 2;
      end
    end
  end

  assign pair_o = pair_q;

  AST_CAP_SPACING: assert property (@(posedge clk_fast_i) disable iff (rst_i)
    cap |=> !cap); // R8

  AST_LOW_UNTIL_PRIMED: assert property (@(posedge clk_fast_i) disable iff (rst_i)
    !primed_q |-> (!pair_q.rise && !pair_q.fall)); // R1

endmodule

// File: rtl/mphase_dds_ddr.sv
module mphase_dds_ddr
  import dds_pkg::*;
#(
  parameter int unsigned ACC_W      = DEF_ACC_W,
  parameter int unsigned NUM_PHASES = DEF_NUM_PHASES
) (
  input  logic                  clk_fab_i,
  input  logic                  clk_fast_i,
  input  logic                  rst_i,
  input  logic [ACC_W-1:0]      tune_word_i,
  input  logic                  tune_load_i,
  output logic                  ser_rise_o,
  output logic                  ser_fall_o,
  output logic [NUM_PHASES-1:0] msb_vec_o
);

  logic [NUM_PHASES-1:0] vec;
  logic                  vec_tgl;
  ddr_pair_t             pair;

  dds_phase_core #(
    .ACC_W     (ACC_W),
    .NUM_PHASES(NUM_PHASES)
  ) core_i (
    .clk_i      (clk_fab_i),
    .rst_i      (rst_i),
    .tune_word_i(tune_word_i),
    .tune_load_i(tune_load_i),
    .msb_vec_o  (vec),
    .vec_tgl_o  (vec_tgl)
  );

  dds_ddr_serializer #(
    .NUM_PHASES(NUM_PHASES)
  ) ser_i (
    .clk_fast_i(clk_fast_i),
    .rst_i     (rst_i),
    .vec_i     (vec),
    .vec_tgl_i (vec_tgl),
    .pair_o    (pair)
  );

  assign msb_vec_o  = vec;
  assign ser_rise_o = pair.rise;
  assign ser_fall_o = pair.fall;

endmodule

// File: tb/mphase_dds_ddr_tb_top.sv
`timescale 1ns/100ps
module mphase_dds_ddr_tb_top;

  localparam int unsigned AW = 32;
  localparam int unsigned NP = 4;

  typedef struct {
    logic [NP-1:0] vec;
    string         tag;
  } exp_t;

  logic          clk_fab, clk_fast, rst;
  logic [AW-1:0] tune_word;
  logic          tune_load;
  logic          ser_rise, ser_fall;
  logic [NP-1:0] msb_vec;

  exp_t          q[$];
  int            compared = 0, mismatched = 0, pushed = 0, popped = 0;
  logic [AW-1:0] m_base = '0, m_inc = '0;

  mphase_dds_ddr #(.ACC_W(AW), .NUM_PHASES(NP)) dut_i (
    .clk_fab_i  (clk_fab),
    .clk_fast_i (clk_fast),
    .rst_i      (rst),
    .tune_word_i(tune_word),
    .tune_load_i(tune_load),
    .ser_rise_o (ser_rise),
    .ser_fall_o (ser_fall),
    .msb_vec_o  (msb_vec)
  );

  // fast 500 MHz, fabric 250 MHz, rising edges aligned
  initial begin
    clk_fast = 1'b0;
    clk_fab  = 1'b0;
    forever begin
      #1;
      clk_fast = ~clk_fast;
      if (clk_fast) clk_fab = ~clk_fab;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [NP-1:0] vec_of(input logic [AW-1:0] b, input logic [AW-1:0] inc);
    logic [NP-1:0] v;
    for (int k = 0; k < NP; k++) begin
      logic [AW-1:0] ph;
      ph   = b + inc * AW'(k);
      v[k] = ph[AW-1];
    end
    return v;
  endfunction

  // driver: applies inputs for one fabric edge, pushes the predicted vector
  task automatic drive(input bit ld, input logic [AW-1:0] tw, input string tag);
    exp_t it;
    tune_load = ld;
    tune_word = tw;
    @(posedge clk_fab);
    it.vec = vec_of(m_base, m_inc);
    it.tag = tag;
    q.push_back(it);
    pushed++;
    m_base = m_base + m_inc * AW'(NP);
    if (ld) m_inc = tw;
    #1;
  endtask

  // monitor: vector mid-period, then the two serial pairs (R6, R7)
  initial begin
    forever begin
      @(negedge clk_fab);
      #0.5;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        popped++;
        check(msb_vec == it.vec, it.tag, 32'(msb_vec), 32'(it.vec));
        check({ser_rise, ser_fall} == {it.vec[0], it.vec[1]}, "R6 first pair",
              32'({ser_rise, ser_fall}), 32'({it.vec[0], it.vec[1]}));
        #2;
        check({ser_rise, ser_fall} == {it.vec[2], it.vec[3]}, "R7 second pair",
              32'({ser_rise, ser_fall}), 32'({it.vec[2], it.vec[3]}));
      end
    end
  end

  initial begin
    #(200000 * 4);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst       = 1'b1;
    tune_load = 1'b1;            // R5: load during reset must be ignored
    tune_word = 32'hDEAD_BEEF;
    repeat (3) @(posedge clk_fab);
    #1.5;
    check(msb_vec == '0, "R1 vector in reset", 32'(msb_vec), 32'h0);
    check(ser_rise == 1'b0, "R1 rise in reset", 32'(ser_rise), 32'h0);
    check(ser_fall == 1'b0, "R1 fall in reset", 32'(ser_fall), 32'h0);
    rst       = 1'b0;
    tune_load = 1'b0;

    repeat (4) drive(1'b0, 32'hDEAD_BEEF, "R5 reset load ignored");
    drive(1'b1, 32'h4000_0000, "R4 quarter-rate load");
    repeat (6) drive(1'b0, 32'h4000_0000, "R2 quarter-rate");
    repeat (4) drive(1'b0, 32'h1357_9BDF, "R5 word without load");
    drive(1'b1, 32'h0F00_0001, "R4 slow load");
    repeat (40) drive(1'b0, 32'h0F00_0001, "R3 accumulate and wrap");
    drive(1'b1, 32'h8000_0000, "R4 half-rate load");
    repeat (4) drive(1'b0, 32'h8000_0000, "R2 half-rate");
    for (int i = 1; i <= 8; i++) drive(1'b1, 32'h0123_4567 * 32'(i), "R4 back-to-back loads");
    for (int i = 0; i < 12; i++) drive(i % 3 == 0, 32'h3000_0001 + 32'(i) * 32'h0111_0000, "R3 load during wrap");
    drive(1'b1, 32'hFFFF_FFF0, "R3 negative step");
    repeat (10) drive(1'b0, 32'h0, "R3 negative step run");
    drive(1'b1, 32'h0, "R4 zero load");
    repeat (4) drive(1'b0, 32'h0, "R2 frozen phase");
    drive(1'b1, 32'h1C71_C71C, "R4 odd ratio load");
    repeat (20) drive(1'b0, 32'h1C71_C71C, "R7 odd ratio run");

    tune_load = 1'b0;
    repeat (3) @(posedge clk_fab);
    #1;
    check(popped == pushed, "R8 every vector emitted", 32'(popped), 32'(pushed));
    check(q.size() == 0, "R8 nothing left over", 32'(q.size()), 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule